// File: doc/BRIEF.md
# Rate-Paced Stream Packet Generator

This block is a packet source for a wide streaming bus. It drives 256-bit beats (32 bytes each) on a valid/ready master port. Continuous valid on that port would carry twice the wanted rate, so the block holds its long-term output to half the bus capacity. It never breaks a packet to do this. Once a packet starts, valid stays high until the final beat is accepted. The rate is shaped only by the idle time left between packets.

A credit register does the pacing. It gains one credit every clock and loses two for each accepted beat. A packet may begin only when the register holds at least twice that packet's beat count. The register saturates at a programmable ceiling. This limits how far a long idle spell, or a long stall by the sink, can push the output above the average rate. The payload is a running count, so a sink or a scoreboard can detect lost, repeated or reordered beats without any extra state. Two counters report the beats and packets that have been accepted.

Top module: `stream_pacer_src`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `m_valid` is low and both counters read zero.
- R2: From the first beat of a packet until the beat carrying `m_last` has been accepted, `m_valid` is high on every cycle.
- R3: While `m_valid` is high and `m_ready` is low, `m_data`, `m_keep` and `m_last` hold their values, and `m_valid` stays high on the next cycle.
- R4: A packet of `pkt_bytes` bytes (1 or more) has ceil(`pkt_bytes`/32) beats, and only the final beat has `m_last` set. `m_keep` is all ones on every beat except the final one. On the final beat it sets bits 0 to r-1, where r = `pkt_bytes` mod 32, or all 32 bits when r is 0.
- R5: On any presented beat, 32-bit lane i (bits 32i+31 down to 32i) equals 8*B + i modulo 2^32. B is the number of beats accepted since reset.
- R6: Credit starts at zero, gains 1 per clock and loses 2 per accepted beat. A packet starts only while `en` is high and credit is at least twice its beat count. Over any window of W cycles, twice the accepted beats is at most W + `credit_cap`.
- R7: Credit never exceeds `credit_cap`. After a long idle spell, the beats accepted in the next W cycles are at most (W + `credit_cap`)/2.
- R8: `beat_cnt` rises by one only on a cycle with both `m_valid` and `m_ready` high. `pkt_cnt` rises by one only when that beat also has `m_last` set. Otherwise both counters hold.
- R9: When `en` is low, no new packet begins, but a packet already in progress completes.
- R10: On the cycle after a beat with `m_last` is accepted, `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows new packets to begin |
| pkt_bytes | input | 16 | Packet length in bytes, sampled when a packet starts |
| credit_cap | input | 16 | Credit saturation ceiling; must be at least twice the beat count |
| m_ready | input | 1 | Sink ready |
| m_data | output | 256 | Beat payload |
| m_keep | output | 32 | Byte enables |
| m_last | output | 1 | Final beat of a packet |
| m_valid | output | 1 | Beat valid |
| beat_cnt | output | 32 | Accepted beats |
| pkt_cnt | output | 32 | Accepted packets |

## Verification
The generator runs against an always-ready sink and against a sink whose ready follows a pseudo-random pattern. The first exposes errors in framing and byte-enables. The second separates correct stall holding from data that moves or valid that drops in the middle of a packet. Lengths that divide evenly into beats and lengths with a one-byte tail check both forms of the final-beat keep. A long free-running window with a small ceiling checks the average rate. A burst measured right after a long idle spell shows whether credit saturates or keeps piling up. A drop of `en` in the middle of a packet checks that the packet still completes and that nothing new starts.

// File: rtl/stream_pacer_src.sv
module stream_pacer_src #(
  parameter int DATA_W = 256,
  parameter int LEN_W  = 16,
  parameter int CRED_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [LEN_W-1:0]    pkt_bytes,
  input  logic [CRED_W-1:0]   credit_cap,
  input  logic                m_ready,
  output logic [DATA_W-1:0]   m_data,
  output logic [DATA_W/8-1:0] m_keep,
  output logic                m_last,
  output logic                m_valid,
  output logic [CNT_W-1:0]    beat_cnt,
  output logic [CNT_W-1:0]    pkt_cnt
);
  localparam int BPB   = DATA_W / 8;
  localparam int BW    = $clog2(BPB);
  localparam int LANES = DATA_W / 32;
  localparam int CW    = ((CRED_W > LEN_W + 1) ? CRED_W : LEN_W + 1) + 1;

  logic              active;
  logic [LEN_W-1:0]  idx, beats_q;
  logic [BW-1:0]     tail_q;
  logic [CRED_W-1:0] credit;

  logic [LEN_W:0]    len_sum;
  logic [LEN_W-1:0]  beats_raw, beats_cfg;
  logic              credit_ok, go, hs;
  logic [CRED_W:0]   cr_inc, cr_nxt;
  logic [31:0]       lane_base;

  assign len_sum   = {1'b0, pkt_bytes} + (LEN_W+1)'(BPB - 1);
  assign beats_raw = LEN_W'(len_sum >> BW);
  assign beats_cfg = (beats_raw == '0) ? LEN_W'(1) : beats_raw;
  assign credit_ok = CW'(credit) >= (CW'(beats_cfg) << 1);
  assign go        = !active && en && credit_ok;
  assign hs        = active && m_ready;

  assign m_valid = active;
  assign m_last  = active && (idx == beats_q - LEN_W'(1));
  assign m_keep  = (m_last && tail_q != '0) ? ~({BPB{1'b1}} << tail_q) : {BPB{1'b1}};

  assign lane_base = 32'(beat_cnt) * 32'(LANES);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign m_data[32*i +: 32] = lane_base + 32'(i);
  end

  assign cr_inc = {1'b0, credit} + (CRED_W+1)'(1);
  always_comb begin
    if (hs) cr_nxt = (cr_inc < (CRED_W+1)'(2)) ? '0 : cr_inc - (CRED_W+1)'(2);
    else    cr_nxt = cr_inc;
    if (cr_nxt > {1'b0, credit_cap}) cr_nxt = {1'b0, credit_cap};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      beats_q  <= LEN_W'(1);
      tail_q   <= '0;
      credit   <= '0;
      beat_cnt <= '0;
      pkt_cnt  <= '0;
    end else begin
      credit <= CRED_W'(cr_nxt);
      if (go) begin
        active  <= 1'b1;
        idx     <= '0;
        beats_q <= beats_cfg;
        tail_q  <= pkt_bytes[BW-1:0];
      end else if (hs) begin
        beat_cnt <= beat_cnt + CNT_W'(1);
        if (m_last) begin
          active  <= 1'b0;
          pkt_cnt <= pkt_cnt + CNT_W'(1);
        end else begin
          idx <= idx + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/stream_pacer_src_chk.sv
module stream_pacer_src_chk #(
  parameter int DATA_W = 256,
  parameter int CRED_W = 16,
  parameter int CNT_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                m_ready,
  input logic [DATA_W-1:0]   m_data,
  input logic [DATA_W/8-1:0] m_keep,
  input logic                m_last,
  input logic                m_valid,
  input logic [CNT_W-1:0]    beat_cnt,
  input logic [CNT_W-1:0]    pkt_cnt,
  input logic [CRED_W-1:0]   credit,
  input logic [CRED_W-1:0]   credit_cap
);
  // R2
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |=> m_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last)));

  // R4
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> (&m_keep));

  // R7
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (credit <= $past(credit_cap)));

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_valid && m_ready) |=> $stable(beat_cnt));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (beat_cnt == $past(beat_cnt) + CNT_W'(1)));

  // R8
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_valid && m_ready && m_last) |=> $stable(pkt_cnt));

  // R10
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid);
endmodule

bind stream_pacer_src stream_pacer_src_chk #(.DATA_W(DATA_W), .CRED_W(CRED_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
  .m_last(m_last), .m_valid(m_valid), .beat_cnt(beat_cnt), .pkt_cnt(pkt_cnt),
  .credit(credit), .credit_cap(credit_cap)
);

// File: tb/sim_stream_pacer_src.sv
module sim_stream_pacer_src;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [15:0]  pkt_bytes = 16'd100;
  logic [15:0]  credit_cap = 16'd64;
  logic         m_ready = 1'b1;
  logic [255:0] m_data;
  logic [31:0]  m_keep;
  logic         m_last, m_valid;
  logic [31:0]  beat_cnt, pkt_cnt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stream_pacer_src u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pkt_bytes(pkt_bytes), .credit_cap(credit_cap),
    .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
    .m_valid(m_valid), .beat_cnt(beat_cnt), .pkt_cnt(pkt_cnt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: samples at negedge; inputs are driven just after posedge
  bit mon_on = 0;
  longint exp_beats = 0, exp_pkts = 0;
  int idx = 0;
  bit p_valid = 0, p_stall = 0, p_lastacc = 0, p_last = 0;
  logic [255:0] p_data;
  logic [31:0]  p_keep;

  always @(negedge clk) begin
    if (mon_on) begin
      int nb, tl;
      logic [31:0] ek;
      nb = (int'(pkt_bytes) + 31) / 32;
      tl = int'(pkt_bytes) % 32;
      if (p_stall)
        check(m_valid && m_data == p_data && m_keep == p_keep && m_last == p_last,
              "R3 stall hold", longint'(m_valid), 1);
      if (p_valid && !p_lastacc)
        check(m_valid, "R2 valid through packet", longint'(m_valid), 1);
      if (p_lastacc)
        check(!m_valid, "R10 idle after last", longint'(m_valid), 0);
      if (m_valid) begin
        for (int i = 0; i < 8; i++) begin
          logic [31:0] ew;
          ew = 32'(exp_beats * 8 + i);
          check(m_data[32*i +: 32] == ew, "R5 lane pattern", longint'(m_data[32*i +: 32]), longint'(ew));
        end
        check(m_last == (idx == nb - 1), "R4 last flag", longint'(m_last), longint'(idx == nb - 1));
        ek = (idx == nb - 1 && tl != 0) ? ((32'd1 << tl) - 32'd1) : 32'hFFFF_FFFF;
        check(m_keep == ek, "R4 keep", longint'(m_keep), longint'(ek));
        check(beat_cnt == 32'(exp_beats), "R8 beat_cnt", longint'(beat_cnt), exp_beats);
        check(pkt_cnt == 32'(exp_pkts), "R8 pkt_cnt", longint'(pkt_cnt), exp_pkts);
      end
      p_valid = m_valid;
      p_stall = m_valid && !m_ready;
      p_last = m_last;
      p_lastacc = m_valid && m_ready && m_last;
      p_data = m_data;
      p_keep = m_keep;
      if (m_valid && m_ready) begin
        exp_beats++;
        if (m_last) begin exp_pkts++; idx = 0; end
        else idx++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic quiesce();
    en = 0; m_ready = 1;
    step(1);
    for (int k = 0; k < 400 && m_valid; k++) step(1);
    step(2);
    check(!m_valid, "R9 quiesce", longint'(m_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(3);
    check(!m_valid && beat_cnt == 0 && pkt_cnt == 0, "R1 in reset", longint'(m_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(!m_valid && beat_cnt == 0 && pkt_cnt == 0, "R1 after reset", longint'(beat_cnt), 0);
    mon_on = 1;
    step(0);
  endtask

  task automatic t_basic(input int len);
    longint p0;
    pkt_bytes = 16'(len); credit_cap = 16'd64; m_ready = 1; en = 1;
    p0 = exp_pkts;
    for (int k = 0; k < 2000 && exp_pkts < p0 + 3; k++) step(1);
    check(exp_pkts >= p0 + 3, "R4 basic packets", exp_pkts - p0, 3);
    quiesce();
    check(pkt_cnt == 32'(exp_pkts), "R8 pkt count after basic", longint'(pkt_cnt), exp_pkts);
  endtask

  task automatic t_stall(input int len);
    logic [7:0] lfsr = 8'hA5;
    longint p0;
    pkt_bytes = 16'(len); credit_cap = 16'd64; en = 1;
    p0 = exp_pkts;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_ready = lfsr[0] | lfsr[2];
      step(1);
    end
    check(exp_pkts > p0 + 3, "R3 progress under stalls", exp_pkts - p0, 4);
    quiesce();
  endtask

  task automatic t_hold_counters();
    logic [31:0] b0, q0;
    pkt_bytes = 16'd96; credit_cap = 16'd64; m_ready = 0; en = 1;
    for (int k = 0; k < 200 && !m_valid; k++) step(1);
    b0 = beat_cnt; q0 = pkt_cnt;
    step(20);
    check(beat_cnt == b0, "R8 beat_cnt holds on stall", longint'(beat_cnt), longint'(b0));
    check(pkt_cnt == q0, "R8 pkt_cnt holds on stall", longint'(pkt_cnt), longint'(q0));
    check(m_valid, "R3 valid held on stall", longint'(m_valid), 1);
    quiesce();
  endtask

  task automatic t_enable_drop();
    longint p0;
    pkt_bytes = 16'd128; credit_cap = 16'd64; m_ready = 0; en = 1;
    for (int k = 0; k < 200 && !m_valid; k++) step(1);
    p0 = exp_pkts;
    en = 0;
    step(5);
    m_ready = 1;
    step(10);
    check(exp_pkts == p0 + 1, "R9 in-flight packet completes", exp_pkts - p0, 1);
    step(50);
    check(!m_valid && exp_pkts == p0 + 1, "R9 no new packet while disabled", exp_pkts - p0, 1);
  endtask

  task automatic t_rate();
    longint b0, nb;
    pkt_bytes = 16'd64; credit_cap = 16'd16; m_ready = 1; en = 1;
    b0 = exp_beats;
    step(2000);
    nb = exp_beats - b0;
    check(2 * nb <= 2000 + 16, "R6 average rate ceiling", 2 * nb, 2016);
    check(2 * nb >= 2000 - 40, "R6 average rate floor", 2 * nb, 1960);
    quiesce();
  endtask

  task automatic t_saturate();
    longint b0, nb;
    pkt_bytes = 16'd128; credit_cap = 16'd8; m_ready = 1; en = 0;
    step(300);
    en = 1;
    b0 = exp_beats;
    step(60);
    nb = exp_beats - b0;
    check(nb <= 35, "R7 burst bounded after idle", nb, 35);
    check(nb >= 18, "R6 packets flow at small ceiling", nb, 18);
    quiesce();
  endtask

  initial begin
    t_reset();
    t_basic(100);
    t_basic(64);
    t_stall(33);
    t_stall(64);
    t_hold_counters();
    t_enable_drop();
    t_rate();
    t_saturate();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule